// File: doc/BRIEF.md
# Exception and Interrupt Control Unit

This unit sits beside the fetch stage of a small 32-bit core and decides when normal instruction flow must be abandoned for a handler. It watches eight level-sensitive interrupt request lines and four one-cycle software exception strobes. It keeps four special registers:

- a control word, holding the per-line interrupt mask, the current and saved kernel-mode bits, and the current and saved global-enable bits;
- a handler vector;
- a cause bitmap;
- the saved return address.

When an exception is taken, the unit does four things. It records the next PC and the causes, shifts the live mode and enable bits into their saved copies, forces kernel mode with interrupts off, and issues a one-cycle redirect to the vector. A return strobe reverses the mode and enable swap and redirects to the saved address. The register access port serves move-to and move-from special register instructions: writes happen on a clock edge, and reads are combinational on the selected address.

Top module: `exc_unit`

## Requirements
- R1: After reset the control word reads 0x008 (kernel mode on, global enable off, every mask bit clear), the vector, return address and cause bitmap read 0, `redirectValid` is 0 and `kernelMode` is 1.
- R2: Register address 0 selects the control word. Bit 3 is kernel mode, bit 2 saved kernel mode, bit 1 global enable, bit 0 saved enable, and bits 11:4 mask lines 0 to 7. Bits 31:12 read as zero, and `kernelMode` follows bit 3.
- R3: An interrupt line n causes entry only when global enable is 1 and mask bit 4+n is 1. `redirectValid` pulses high for one cycle in the cycle after the clock edge that saw the request.
- R4: Any nonzero `swExc` pattern causes entry whatever the enable and mask bits hold.
- R5: On entry, the return address register (address 3) takes `nextPc`, the saved bits take the live ones, kernel mode becomes 1, global enable becomes 0, and `redirectPc` equals the vector register (address 1).
- R6: The cause bitmap (address 2) holds the interrupt lines sampled at the previous clock edge in bits 11:4. Bits 15:12 hold the `swExc` pattern captured at entry: `swExc` bit 0 is protection fault, bit 1 system call, bit 2 breakpoint, bit 3 arithmetic. All other bits read zero, and a write changes only bits 15:12.
- R7: A return strobe copies the saved enable and kernel-mode bits back to the live ones, leaves the saved bits unchanged, and redirects to the return address in the following cycle.
- R8: An enabled-by-mask request that arrives while global enable is 0 stays pending with no redirect, and is taken on the clock edge after software sets global enable.
- R9: Entry takes precedence over a same-cycle return strobe and register write, both of which are dropped. A return strobe takes precedence over a same-cycle register write, which is dropped.
- R10: The vector and return address registers hold and read back all 32 bits written.
- R11: A software exception and an enabled interrupt in the same cycle cause a single entry whose cause bitmap shows both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| nextPc | input | 32 | Address of the instruction about to execute |
| irqLines | input | 8 | Level interrupt request lines 0 to 7 |
| swExc | input | 4 | Software exception strobes (fault, syscall, break, arithmetic) |
| rfeStrobe | input | 1 | Return-from-exception request |
| regWrEn | input | 1 | Special register write enable |
| regAddr | input | 2 | Special register select: 0 control, 1 vector, 2 causes, 3 return address |
| regWrData | input | 32 | Special register write data |
| regRdData | output | 32 | Special register read data for `regAddr` |
| redirectValid | output | 1 | One-cycle redirect pulse |
| redirectPc | output | 32 | Redirect target |
| kernelMode | output | 1 | Current kernel-mode bit |

## Verification
Entry, return and register writes all change the control word, so they can collide on one edge. Software exceptions and interrupts can also collide, since both feed entry. The bench asserts a system call, an unmasked interrupt, a return strobe and a vector write together. It then reads back that exactly one entry happened, that the vector keeps its old value, and that the cause bitmap carries both sources. A second collision pairs a return strobe with a control word write and expects the restored bits, not the written ones.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam logic [1:0] SR_CTRL = 2'd0;
  localparam logic [1:0] SR_VEC  = 2'd1;
  localparam logic [1:0] SR_STAT = 2'd2;
  localparam logic [1:0] SR_EAR  = 2'd3;

  localparam int BIT_OIE = 0;
  localparam int BIT_IE  = 1;
  localparam int BIT_OKU = 2;
  localparam int BIT_KU  = 3;
  localparam int MASK_LO = 4;

  typedef struct packed {
    logic takeExc;
    logic doRfe;
    logic wrCtrl;
    logic wrVec;
    logic wrStat;
    logic wrEar;
  } excStrobes_t;
endpackage

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int NUM_SW  = 4
) (
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic [NUM_SW-1:0]  swExc,
  input  logic               ieBit,
  input  logic [NUM_IRQ-1:0] irqMask,
  input  logic               rfeStrobe,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  output excStrobes_t        strobes
);
  logic irqHit;
  logic swHit;
  logic wrOk;

  always_comb begin
    irqHit = ieBit && (|(irqLines & irqMask));
    swHit  = |swExc;
    strobes.takeExc = swHit || irqHit;
    strobes.doRfe   = rfeStrobe && !strobes.takeExc;
    wrOk            = regWrEn && !strobes.takeExc && !rfeStrobe;
    strobes.wrCtrl  = wrOk && (regAddr == SR_CTRL);
    strobes.wrVec   = wrOk && (regAddr == SR_VEC);
    strobes.wrStat  = wrOk && (regAddr == SR_STAT);
    strobes.wrEar   = wrOk && (regAddr == SR_EAR);
  end
endmodule

// File: rtl/exc_datapath.sv
module exc_datapath
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 8,
  parameter int NUM_SW  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  excStrobes_t        strobes,
  input  logic [XLEN-1:0]    nextPc,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic [NUM_SW-1:0]  swExc,
  input  logic [1:0]         regAddr,
  input  logic [XLEN-1:0]    regWrData,
  output logic [XLEN-1:0]    regRdData,
  output logic               ieBit,
  output logic               oieBit,
  output logic               kuBit,
  output logic               okuBit,
  output logic [NUM_IRQ-1:0] irqMask,
  output logic [XLEN-1:0]    vecVal,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc
);
  localparam int MASK_HI = MASK_LO + NUM_IRQ - 1;
  localparam int CTRL_W  = MASK_HI + 1;
  localparam logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(1) << BIT_KU;

  logic [CTRL_W-1:0]  ctrlQ;
  logic [XLEN-1:0]    vecQ;
  logic [XLEN-1:0]    earQ;
  logic [NUM_SW-1:0]  swQ;
  logic [NUM_IRQ-1:0] irqQ;
  logic               redirValidQ;
  logic [XLEN-1:0]    redirPcQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ       <= CTRL_RST;
      vecQ        <= '0;
      earQ        <= '0;
      swQ         <= '0;
      irqQ        <= '0;
      redirValidQ <= 1'b0;
      redirPcQ    <= '0;
    end else begin
      irqQ        <= irqLines;
      redirValidQ <= strobes.takeExc || strobes.doRfe;
      if (strobes.takeExc) begin
        earQ            <= nextPc;
        swQ             <= swExc;
        ctrlQ[BIT_OIE]  <= ctrlQ[BIT_IE];
        ctrlQ[BIT_OKU]  <= ctrlQ[BIT_KU];
        ctrlQ[BIT_IE]   <= 1'b0;
        ctrlQ[BIT_KU]   <= 1'b1;
        redirPcQ        <= vecQ;
      end else if (strobes.doRfe) begin
        ctrlQ[BIT_IE]   <= ctrlQ[BIT_OIE];
        ctrlQ[BIT_KU]   <= ctrlQ[BIT_OKU];
        redirPcQ        <= earQ;
      end else begin
        if (strobes.wrCtrl) ctrlQ <= regWrData[CTRL_W-1:0];
        if (strobes.wrVec)  vecQ  <= regWrData;
        if (strobes.wrStat) swQ   <= regWrData[CTRL_W +: NUM_SW];
        if (strobes.wrEar)  earQ  <= regWrData;
      end
    end
  end

  always_comb begin
    unique case (regAddr)
      SR_CTRL: regRdData = XLEN'(ctrlQ);
      SR_VEC:  regRdData = vecQ;
      SR_STAT: regRdData = XLEN'({swQ, irqQ, {MASK_LO{1'b0}}});
      default: regRdData = earQ;
    endcase
  end

  assign ieBit         = ctrlQ[BIT_IE];
  assign oieBit        = ctrlQ[BIT_OIE];
  assign kuBit         = ctrlQ[BIT_KU];
  assign okuBit        = ctrlQ[BIT_OKU];
  assign irqMask       = ctrlQ[MASK_HI:MASK_LO];
  assign vecVal        = vecQ;
  assign redirectValid = redirValidQ;
  assign redirectPc    = redirPcQ;
endmodule

// File: rtl/exc_unit.sv
module exc_unit
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 8,
  parameter int NUM_SW  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [XLEN-1:0]    nextPc,
  input  logic [NUM_IRQ-1:0] irqLines,
  input  logic [NUM_SW-1:0]  swExc,
  input  logic               rfeStrobe,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [XLEN-1:0]    regWrData,
  output logic [XLEN-1:0]    regRdData,
  output logic               redirectValid,
  output logic [XLEN-1:0]    redirectPc,
  output logic               kernelMode
);
  excStrobes_t        strobes;
  logic               ieBit;
  logic               oieBit;
  logic               kuBit;
  logic               okuBit;
  logic [NUM_IRQ-1:0] irqMask;
  logic [XLEN-1:0]    vecVal;

  exc_ctrl #(.NUM_IRQ(NUM_IRQ), .NUM_SW(NUM_SW)) uCtrl (
    .irqLines (irqLines),
    .swExc    (swExc),
    .ieBit    (ieBit),
    .irqMask  (irqMask),
    .rfeStrobe(rfeStrobe),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .strobes  (strobes)
  );

  exc_datapath #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .NUM_SW(NUM_SW)) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .nextPc       (nextPc),
    .irqLines     (irqLines),
    .swExc        (swExc),
    .regAddr      (regAddr),
    .regWrData    (regWrData),
    .regRdData    (regRdData),
    .ieBit        (ieBit),
    .oieBit       (oieBit),
    .kuBit        (kuBit),
    .okuBit       (okuBit),
    .irqMask      (irqMask),
    .vecVal       (vecVal),
    .redirectValid(redirectValid),
    .redirectPc   (redirectPc)
  );

  assign kernelMode = kuBit;
endmodule

// File: rtl/exc_unit_chk.sv
module exc_unit_chk #(
  parameter int XLEN    = 32,
  parameter int NUM_IRQ = 8,
  parameter int NUM_SW  = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_IRQ-1:0] irqLines,
  input logic [NUM_SW-1:0]  swExc,
  input logic               rfeStrobe,
  input logic [1:0]         regAddr,
  input logic [XLEN-1:0]    regRdData,
  input logic               redirectValid,
  input logic [XLEN-1:0]    redirectPc,
  input logic               kernelMode,
  input logic               ieBit,
  input logic               oieBit,
  input logic               okuBit,
  input logic [NUM_IRQ-1:0] irqMask,
  input logic [XLEN-1:0]    vecVal
);
  localparam int STAT_W = 4 + NUM_IRQ + NUM_SW;

  // R5
  entry_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|swExc) |=> (kernelMode && !ieBit && redirectValid));

  // R4
  sw_vector_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|swExc) |=> (redirectPc == $past(vecVal)));

  // R3
  irq_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ieBit && (swExc == '0) && !rfeStrobe) |=> !redirectValid);

  // R7
  rfe_restore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rfeStrobe && (swExc == '0) && !(ieBit && (|(irqLines & irqMask))))
      |=> (redirectValid && (kernelMode == $past(okuBit)) && (ieBit == $past(oieBit))));

  // R6
  status_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2) |-> (regRdData[XLEN-1:STAT_W] == '0));
endmodule

bind exc_unit exc_unit_chk #(.XLEN(XLEN), .NUM_IRQ(NUM_IRQ), .NUM_SW(NUM_SW)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .irqLines     (irqLines),
  .swExc        (swExc),
  .rfeStrobe    (rfeStrobe),
  .regAddr      (regAddr),
  .regRdData    (regRdData),
  .redirectValid(redirectValid),
  .redirectPc   (redirectPc),
  .kernelMode   (kernelMode),
  .ieBit        (ieBit),
  .oieBit       (oieBit),
  .okuBit       (okuBit),
  .irqMask      (irqMask),
  .vecVal       (vecVal)
);

// File: tb/tb_exc_unit.sv
module tb_exc_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] nextPc;
  logic [7:0]  irqLines;
  logic [3:0]  swExc;
  logic        rfeStrobe;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        redirectValid;
  logic [31:0] redirectPc;
  logic        kernelMode;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_unit dut (
    .clk(clk), .rstN(rstN), .nextPc(nextPc), .irqLines(irqLines), .swExc(swExc),
    .rfeStrobe(rfeStrobe), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .redirectValid(redirectValid), .redirectPc(redirectPc),
    .kernelMode(kernelMode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    rstN = 1'b0; nextPc = '0; irqLines = '0; swExc = '0; rfeStrobe = 1'b0;
    regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 redirectValid", 32'(redirectValid), 0);
    chk("R1 kernelMode", 32'(kernelMode), 1);
    rd(0, d); chk("R1 ctrl", d, 32'h8);
    rd(1, d); chk("R1 vec", d, 0);
    rd(2, d); chk("R1 stat", d, 0);
    rd(3, d); chk("R1 ear", d, 0);

    // R2 control word width and kernel bit
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R2 ctrl all ones", d, 32'h0000_0FFF);
    chk("R2 kernelMode", 32'(kernelMode), 1);
    wr(0, 32'h22);
    rd(0, d); chk("R2 ctrl 0x22", d, 32'h22);
    chk("R2 kernelMode user", 32'(kernelMode), 0);

    // R10 full-width vector and return address
    wr(1, 32'hA5A5_5A5A); rd(1, d); chk("R10 vec", d, 32'hA5A5_5A5A);
    wr(3, 32'h1234_5678); rd(3, d); chk("R10 ear", d, 32'h1234_5678);
    // R6 status write touches cause bits only
    wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R6 stat write", d, 32'h0000_F000);

    // R3 R5 R6 sweep: line x mask bit x global enable
    wr(1, 32'h0000_1000);
    for (int ie = 0; ie < 2; ie++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          logic take;
          logic [31:0] maskW;
          maskW = 32'(1) << (4 + j);
          take = (ie == 1) && (i == j);
          wr(0, maskW | 32'h8 | (ie == 1 ? 32'h2 : 32'h0));
          nextPc = 32'h4000 + 32'(i * 64 + j * 4);
          irqLines = 8'(1 << i);
          @(negedge clk);
          chk("R3 irq take", 32'(redirectValid), 32'(take));
          if (take) begin
            chk("R5 redirectPc", redirectPc, 32'h1000);
            rd(0, d); chk("R5 ctrl after entry", d, maskW | 32'hD);
            rd(2, d); chk("R6 stat irq", d, 32'(1) << (4 + i));
            rd(3, d); chk("R5 ear", d, nextPc);
          end
          irqLines = '0;
          @(negedge clk);
          chk("R3 single pulse", 32'(redirectValid), 0);
        end
      end
    end

    // R4 R5 R6 R7 sweep of software cause patterns, user mode
    wr(1, 32'h0000_8000);
    for (int p = 1; p < 16; p++) begin
      logic odd;
      odd = p[0];
      wr(0, odd ? 32'h2 : 32'h0);
      nextPc = 32'h200 + 32'(p * 4);
      swExc = 4'(p);
      @(negedge clk);
      swExc = '0;
      chk("R4 sw take", 32'(redirectValid), 1);
      chk("R4 sw redirectPc", redirectPc, 32'h8000);
      chk("R5 sw kernelMode", 32'(kernelMode), 1);
      rd(0, d); chk("R5 sw ctrl", d, odd ? 32'h9 : 32'h8);
      rd(2, d); chk("R6 sw causes", d, 32'(p) << 12);
      rd(3, d); chk("R5 sw ear", d, 32'h200 + 32'(p * 4));
      rfeStrobe = 1'b1;
      @(negedge clk);
      rfeStrobe = 1'b0;
      chk("R7 rfe redirect", 32'(redirectValid), 1);
      chk("R7 rfe target", redirectPc, 32'h200 + 32'(p * 4));
      chk("R7 rfe kernelMode", 32'(kernelMode), 0);
      rd(0, d); chk("R7 rfe ctrl", d, odd ? 32'h3 : 32'h0);
    end

    // R8 pending request taken once enable is set
    wr(0, 32'h18);
    irqLines = 8'h01;
    repeat (3) @(negedge clk);
    chk("R8 held off", 32'(redirectValid), 0);
    wr(0, 32'h1A);
    chk("R8 not yet", 32'(redirectValid), 0);
    @(negedge clk);
    chk("R8 taken", 32'(redirectValid), 1);
    irqLines = '0;
    @(negedge clk);

    // R9 R11 entry beats return strobe and write; both causes recorded
    wr(0, 32'hFF2);
    nextPc = 32'h0000_0ABC;
    swExc = 4'b0010; irqLines = 8'h01; rfeStrobe = 1'b1;
    regWrEn = 1'b1; regAddr = 1; regWrData = 32'h0000_DEAD;
    @(negedge clk);
    swExc = '0; irqLines = '0; rfeStrobe = 1'b0; regWrEn = 1'b0;
    chk("R9 entry redirect", redirectPc, 32'h8000);
    rd(1, d); chk("R9 write dropped", d, 32'h8000);
    rd(0, d); chk("R9 ctrl entry", d, 32'hFF9);
    rd(2, d); chk("R11 both causes", d, 32'h0000_2010);
    // R9 return beats write
    rfeStrobe = 1'b1; regWrEn = 1'b1; regAddr = 0; regWrData = 32'h0;
    @(negedge clk);
    rfeStrobe = 1'b0; regWrEn = 1'b0;
    chk("R9 rfe redirect", redirectPc, 32'h0000_0ABC);
    rd(0, d); chk("R9 ctrl rfe over write", d, 32'hFF3);

    finishRun();
  end
endmodule